// File: doc/BRIEF.md
# Delta-Derivative Fault Phase Selector

This block decides which phases a power-line fault involves. Each sample it takes the superimposed (fault-only) derivatives of the three phase currents. From them it forms six loop quantities: the three single-phase values A, B and C, and the three pair differences A−B, B−C and C−A. Working from derivatives keeps any decaying DC offset out of the decision.

A start pulse from the fault detector opens a window of a fixed number of accepted samples (four by default). Over that window the block sums the absolute value of each loop. When the window closes, it compares the six sums by ratio tests built from shifts and latches a fault code. The code names a single phase to ground, a phase pair, or all three phases. A done strobe marks the new code. The selection is trusted only when the total of the three pair sums is above a programmable threshold. When that test fails, or when no classification rule matches, a fallback flag tells the surrounding logic to use a slower method.

Top module: `delta_phase_sel`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `code_o`, `valid_o` and `fallback_o` are all zero until a first window completes.
- R2: The sums hold the absolute values of the loops |A|, |B|, |C|, |A−B|, |B−C| and |C−A|, added over NWIN accepted samples. A window is opened by `start_i`, and a sample present in the start cycle counts as the first one. Samples arriving while no window is open have no effect on any output.
- R3: `done_o` is high for exactly one cycle, one clock after the edge that accepts the final sample of a window. Code, valid and fallback change only together with `done_o` and hold between strobes.
- R4: `valid_o` is 1 only when SAB+SBC+SCA is strictly greater than `thr_i`. Otherwise `fallback_o` is 1 and `code_o` is 0000.
- R5: Code bit 0 flags phase A, bit 1 phase B and bit 2 phase C. Bit 3 is the ground flag and is set only together with exactly one phase bit.
- R6: Single-phase fault on phase X. Two conditions must both hold. First, the pair sum that excludes X, shifted left by `much_shift_i`, is below both other pair sums. Second, X's phase sum exceeds each other phase sum shifted left by `much_shift_i`. The code is then the ground flag plus X.
- R7: Three-phase fault. Every one of the six sums is at least the largest sum shifted right by `near_shift_i`. The code is then 0111 with no ground flag.
- R8: Two-phase fault. One phase sum, shifted left by `much_shift_i`, is below both other phase sums. The code then flags the other two phases, with no ground flag.
- R9: The rules are applied in the order R6, R7, R8. A valid window that matches none of them gives code 0000 with `valid_o`=1 and `fallback_o`=1.
- R10: `start_i` during an open window discards the partial sums and restarts the count. This also applies when it coincides with what would have been the final sample, in which case no done strobe follows.
- R11: A `start_i` in the cycle in which a finished window's result is being latched does not disturb that result. The new window proceeds normally.
- R12: Cycles with `smp_vld_i` low inside a window are not counted and do not change the sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Fault detected: open a new window |
| smp_vld_i | input | 1 | A new sample is present on the derivative inputs |
| dia_i | input | DW (16) | Signed superimposed derivative, phase A |
| dib_i | input | DW (16) | Signed superimposed derivative, phase B |
| dic_i | input | DW (16) | Signed superimposed derivative, phase C |
| much_shift_i | input | SHW (3) | Shift setting the "much smaller" ratio (2^n) |
| near_shift_i | input | SHW (3) | Shift setting the "comparable" ratio (2^-n) |
| thr_i | input | TW (22) | Validity threshold on the sum of pair loop sums |
| done_o | output | 1 | One-cycle strobe: new result latched |
| code_o | output | 4 | {ground, C, B, A} fault code |
| valid_o | output | 1 | Pair-sum total exceeded the threshold |
| fallback_o | output | 1 | Result unusable; use the fallback method |

## Verification
Two things can happen in the same clock cycle. The first is that the result of a finished window is being latched while a start pulse with its first sample opens the next window. The bench provokes this by driving start together with a sample in the cycle right after a window's last sample. It then expects the old code on the strobe and, four samples later, the new window's own code. The second is that a start coincides with what would have been a window's final sample. The bench drives exactly that and expects no strobe where the old window would have ended, followed by a result built only from samples taken after the restart.

// File: rtl/dps_pkg.sv
// Package: shared constants and types for the delta-derivative phase selector.
// Assumes six loops ordered phase A, B, C, then pairs AB, BC, CA.
package dps_pkg;
    localparam int LOOPS = 6;
    localparam int NPH   = 3;
    // fault code bit positions
    localparam int BIT_A = 0;
    localparam int BIT_B = 1;
    localparam int BIT_C = 2;
    localparam int BIT_G = 3;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_SINGLE = 2'd1,
        K_THREE  = 2'd2,
        K_TWO    = 2'd3
    } fault_kind_e;
endpackage

// File: rtl/dps_loop_form.sv
// Module: forms the six loop magnitudes from the three signed phase deltas.
// Outputs |A|,|B|,|C| in slots 0..2 and |A-B|,|B-C|,|C-A| in slots 3..5.
// Assumes MW >= DW+1 so every difference magnitude fits without overflow.
module dps_loop_form
    import dps_pkg::*;
#(
    parameter int DW = 16,
    parameter int MW = DW + 1
) (
    input  logic signed [DW-1:0]         ph_a,
    input  logic signed [DW-1:0]         ph_b,
    input  logic signed [DW-1:0]         ph_c,
    output logic [LOOPS-1:0][MW-1:0]     mag
);
    localparam int EXT = MW + 1 - DW;

    logic signed [MW:0] ph [NPH];

    // absolute value of a widened signed quantity
    function automatic logic [MW-1:0] absv(input logic signed [MW:0] x);
        logic signed [MW:0] n;
        n = x[MW] ? -x : x;
        return n[MW-1:0];
    endfunction

    assign ph[0] = {{EXT{ph_a[DW-1]}}, ph_a};
    assign ph[1] = {{EXT{ph_b[DW-1]}}, ph_b};
    assign ph[2] = {{EXT{ph_c[DW-1]}}, ph_c};

    // phase loop i and pair loop (i, i+1 mod 3)
    for (genvar i = 0; i < NPH; i++) begin : g_loop
        assign mag[i]       = absv(ph[i]);
        assign mag[NPH + i] = absv(ph[i] - ph[(i + 1) % NPH]);
    end
endmodule

// File: rtl/dps_win_accum.sv
// Module: window control and the six loop accumulators.
// A start opens a window (its sample, if present, is the first); the window
// closes after NWIN accepted samples and win_done pulses with final sums.
// Assumes NWIN >= 2.
module dps_win_accum
    import dps_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int MW   = 17,
    parameter int SW   = MW + $clog2(NWIN) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      smp_vld,
    input  logic [LOOPS-1:0][MW-1:0]  mag,
    output logic [LOOPS-1:0][SW-1:0]  sums,
    output logic                      win_done
);
    localparam int CW = $clog2(NWIN + 1);

    logic          armed;
    logic [CW-1:0] cnt;
    logic          take;
    logic          last;

    assign take = armed && smp_vld && !start;
    assign last = (cnt == CW'(NWIN - 1));

    // window sequencing: arm on start, count accepted samples, close at NWIN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            cnt      <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= 1'b0;
            if (start) begin
                armed <= 1'b1;
                cnt   <= smp_vld ? CW'(1) : '0;
            end else if (take) begin
                cnt <= cnt + CW'(1);
                if (last) begin
                    armed    <= 1'b0;
                    win_done <= 1'b1;
                    cnt      <= '0;
                end
            end
        end
    end

    // one accumulator per loop: restart on start, add magnitude per sample
    for (genvar i = 0; i < LOOPS; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sums[i] <= '0;
            end else if (start) begin
                sums[i] <= smp_vld ? SW'(mag[i]) : '0;
            end else if (take) begin
                sums[i] <= sums[i] + SW'(mag[i]);
            end
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(NWIN));

    p_close_on_sample_r12: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(smp_vld) && !$past(start));

    p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !win_done);
endmodule

// File: rtl/dps_classify.sv
// Module: combinational fault classifier over the six window sums.
// Ratio tests use shifts: "much smaller" is x<<much < y, "comparable" is
// x >= max>>near. Priority: single-phase, three-phase, two-phase.
// Assumes sums are stable for the cycle in which the result is latched.
module dps_classify
    import dps_pkg::*;
#(
    parameter int SW  = 20,
    parameter int SHW = 3,
    parameter int TW  = SW + 2
) (
    input  logic [LOOPS-1:0][SW-1:0] sums,
    input  logic [SHW-1:0]           much_sh,
    input  logic [SHW-1:0]           near_sh,
    input  logic [TW-1:0]            thr,
    output logic [3:0]               code,
    output logic                     valid,
    output logic                     fallback
);
    localparam int CW = SW + (1 << SHW);

    logic [CW-1:0]    w [LOOPS];
    logic [TW-1:0]    pair_total;
    logic [NPH-1:0]   sgl;
    logic [NPH-1:0]   two;
    logic             three;
    logic [CW-1:0]    mx;
    fault_kind_e      kind;
    logic [1:0]       idx;

    for (genvar k = 0; k < LOOPS; k++) begin : g_wide
        assign w[k] = CW'(sums[k]);
    end

    assign pair_total = TW'(sums[NPH]) + TW'(sums[NPH+1]) + TW'(sums[NPH+2]);
    assign valid      = pair_total > thr;

    // per-phase single-phase and quiet-phase tests
    for (genvar i = 0; i < NPH; i++) begin : g_phase
        localparam int OPP = NPH + (i + 1) % NPH;
        localparam int PX  = NPH + i;
        localparam int PY  = NPH + (i + 2) % NPH;
        localparam int Q1  = (i + 1) % NPH;
        localparam int Q2  = (i + 2) % NPH;
        assign sgl[i] = ((w[OPP] << much_sh) < w[PX]) &&
                        ((w[OPP] << much_sh) < w[PY]) &&
                        (w[i] > (w[Q1] << much_sh)) &&
                        (w[i] > (w[Q2] << much_sh));
        assign two[i] = ((w[i] << much_sh) < w[Q1]) &&
                        ((w[i] << much_sh) < w[Q2]);
    end

    // largest of the six sums and the comparability test against it
    always_comb begin
        mx = '0;
        for (int k = 0; k < LOOPS; k++) begin
            if (w[k] > mx) mx = w[k];
        end
        three = 1'b1;
        for (int k = 0; k < LOOPS; k++) begin
            if (w[k] < (mx >> near_sh)) three = 1'b0;
        end
    end

    // pick the fault kind in priority order and the phase it refers to
    always_comb begin
        kind = K_NONE;
        idx  = 2'd0;
        if (valid) begin
            if (|sgl) begin
                kind = K_SINGLE;
                for (int i = NPH - 1; i >= 0; i--) begin
                    if (sgl[i]) idx = 2'(i);
                end
            end else if (three) begin
                kind = K_THREE;
            end else if (|two) begin
                kind = K_TWO;
                for (int i = NPH - 1; i >= 0; i--) begin
                    if (two[i]) idx = 2'(i);
                end
            end
        end
    end

    // build the {ground, C, B, A} code from the chosen kind
    always_comb begin
        code     = 4'b0000;
        fallback = 1'b0;
        case (kind)
            K_SINGLE: begin
                code[BIT_G] = 1'b1;
                code[idx]   = 1'b1;
            end
            K_THREE: begin
                code[BIT_C:BIT_A] = 3'b111;
            end
            K_TWO: begin
                code[BIT_C:BIT_A] = 3'b111;
                code[idx]         = 1'b0;
            end
            default: fallback = 1'b1;
        endcase
    end
endmodule

// File: rtl/delta_phase_sel.sv
// Module: top of the delta-derivative phase selector. Forms loops,
// accumulates over a start-triggered window, classifies and latches the
// result with a one-cycle done strobe. Outputs hold between strobes.
module delta_phase_sel
    import dps_pkg::*;
#(
    parameter int  DW   = 16,
    parameter int  NWIN = 4,
    parameter int  SHW  = 3,
    localparam int TW   = DW + $clog2(NWIN) + 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 smp_vld_i,
    input  logic signed [DW-1:0] dia_i,
    input  logic signed [DW-1:0] dib_i,
    input  logic signed [DW-1:0] dic_i,
    input  logic [SHW-1:0]       much_shift_i,
    input  logic [SHW-1:0]       near_shift_i,
    input  logic [TW-1:0]        thr_i,
    output logic                 done_o,
    output logic [3:0]           code_o,
    output logic                 valid_o,
    output logic                 fallback_o
);
    localparam int MW = DW + 1;
    localparam int SW = MW + $clog2(NWIN) + 1;

    logic [LOOPS-1:0][MW-1:0] mag;
    logic [LOOPS-1:0][SW-1:0] sums;
    logic                     win_done;
    logic [3:0]               cls_code;
    logic                     cls_valid;
    logic                     cls_fb;

    dps_loop_form #(.DW(DW), .MW(MW)) u_form (
        .ph_a (dia_i),
        .ph_b (dib_i),
        .ph_c (dic_i),
        .mag  (mag)
    );

    dps_win_accum #(.NWIN(NWIN), .MW(MW), .SW(SW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .smp_vld  (smp_vld_i),
        .mag      (mag),
        .sums     (sums),
        .win_done (win_done)
    );

    dps_classify #(.SW(SW), .SHW(SHW), .TW(TW)) u_cls (
        .sums     (sums),
        .much_sh  (much_shift_i),
        .near_sh  (near_shift_i),
        .thr      (thr_i),
        .code     (cls_code),
        .valid    (cls_valid),
        .fallback (cls_fb)
    );

    // result register: capture the classification when a window closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            code_o     <= '0;
            valid_o    <= 1'b0;
            fallback_o <= 1'b0;
        end else begin
            done_o <= win_done;
            if (win_done) begin
                code_o     <= cls_code;
                valid_o    <= cls_valid;
                fallback_o <= cls_fb;
            end
        end
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(code_o) && $stable(valid_o) && $stable(fallback_o));

    p_invalid_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !valid_o |-> fallback_o && (code_o == 4'b0000));

    p_ground_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && code_o[BIT_G] |-> ($countones(code_o[BIT_C:BIT_A]) == 1));

    p_fallback_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fallback_o |-> (code_o == 4'b0000));
endmodule

// File: tb/delta_phase_sel_test.sv
// Directed bench for the delta-derivative phase selector.
module delta_phase_sel_test;
    localparam int CLK_P = 10;
    localparam int TW    = 22;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start_i;
    logic               smp_vld_i;
    logic signed [15:0] dia_i, dib_i, dic_i;
    logic [2:0]         much_shift_i, near_shift_i;
    logic [TW-1:0]      thr_i;
    logic               done_o;
    logic [3:0]         code_o;
    logic               valid_o;
    logic               fallback_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    delta_phase_sel uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_vld_i(smp_vld_i),
        .dia_i(dia_i), .dib_i(dib_i), .dic_i(dic_i),
        .much_shift_i(much_shift_i), .near_shift_i(near_shift_i), .thr_i(thr_i),
        .done_o(done_o), .code_o(code_o), .valid_o(valid_o), .fallback_o(fallback_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs at the falling edge
    task automatic drv(input bit st, input bit v, input int a, input int b, input int c);
        @(negedge clk);
        start_i   = st;
        smp_vld_i = v;
        dia_i     = 16'(a);
        dib_i     = 16'(b);
        dic_i     = 16'(c);
    endtask

    // drive and confirm no strobe is showing
    task automatic drv_nd(input string tag, input bit st, input bit v,
                          input int a, input int b, input int c);
        drv(st, v, a, b, c);
        chk(tag, int'(done_o), 0);
    endtask

    task automatic win4(input int a, input int b, input int c);
        drv(1, 1, a, b, c);
        for (int k = 0; k < 3; k++) drv_nd("R10 no early done", 0, 1, a, b, c);
    endtask

    // final sample taken at the previous edge: strobe must show one clock later
    task automatic expect_done(input string tag, input int ecode, input int evld, input int efb);
        drv(0, 0, 0, 0, 0);
        chk({tag, " R3 done not yet"}, int'(done_o), 0);
        drv(0, 0, 0, 0, 0);
        chk({tag, " R3 done"}, int'(done_o), 1);
        chk({tag, " code"}, int'(code_o), ecode);
        chk({tag, " valid"}, int'(valid_o), evld);
        chk({tag, " fallback"}, int'(fallback_o), efb);
        drv(0, 0, 0, 0, 0);
        chk({tag, " R3 one-cycle pulse"}, int'(done_o), 0);
    endtask

    task automatic cfg(input int ms, input int ns, input int th);
        much_shift_i = 3'(ms);
        near_shift_i = 3'(ns);
        thr_i        = TW'(th);
    endtask

    task automatic t_reset;
        chk("R1 done", int'(done_o), 0);
        chk("R1 code", int'(code_o), 0);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 fallback", int'(fallback_o), 0);
    endtask

    task automatic t_single_a;    // R6 R5 R2
        cfg(2, 1, 100);
        win4(100, 0, 0);
        expect_done("R6 single A", 4'b1001, 1, 0);
    endtask

    task automatic t_single_c_neg; // R2 abs of negative deltas, R6
        cfg(2, 1, 100);
        win4(0, 0, -80);
        expect_done("R2 R6 single C negative", 4'b1100, 1, 0);
    endtask

    task automatic t_two_bc;      // R8
        cfg(2, 1, 100);
        win4(0, 100, -100);
        expect_done("R8 pair BC", 4'b0110, 1, 0);
    endtask

    task automatic t_three;       // R7 rotating pattern, all six sums 300
        cfg(2, 1, 100);
        drv(1, 1, 100, -50, -50);
        drv_nd("R7 no early done", 0, 1, -50, 100, -50);
        drv_nd("R7 no early done", 0, 1, -50, -50, 100);
        drv_nd("R7 no early done", 0, 1, 100, 100, 100);
        expect_done("R7 three-phase", 4'b0111, 1, 0);
    endtask

    task automatic t_unresolved;  // R9
        cfg(2, 1, 100);
        win4(100, -50, -50);
        expect_done("R9 unresolved", 4'b0000, 1, 1);
    endtask

    task automatic t_threshold;   // R4 boundary: total 200 vs 208
        cfg(2, 1, 200);
        win4(25, 0, 0);
        expect_done("R4 at threshold", 4'b0000, 0, 1);
        win4(26, 0, 0);
        expect_done("R4 above threshold", 4'b1001, 1, 0);
    endtask

    task automatic t_ratio;       // R6 much-smaller ratio is programmable
        cfg(4, 1, 100);
        win4(100, 10, 10);
        expect_done("R6 ratio 16 rejects", 4'b0000, 1, 1);
        cfg(2, 1, 100);
        win4(100, 10, 10);
        expect_done("R6 ratio 4 accepts", 4'b1001, 1, 0);
    endtask

    task automatic t_gap;         // R12 invalid cycles are not counted
        cfg(2, 1, 100);
        drv(1, 1, 100, 0, 0);
        drv_nd("R12 gap", 0, 0, 0, 900, -900);
        drv_nd("R12 gap", 0, 1, 100, 0, 0);
        drv_nd("R12 gap", 0, 0, 0, 900, -900);
        drv_nd("R12 gap", 0, 0, 0, 900, -900);
        drv_nd("R12 gap", 0, 1, 100, 0, 0);
        drv_nd("R12 gap", 0, 1, 100, 0, 0);
        expect_done("R12 gapped window", 4'b1001, 1, 0);
    endtask

    task automatic t_idle;        // R2 samples with no open window are ignored
        for (int k = 0; k < 6; k++) drv_nd("R2 idle no done", 0, 1, 0, 100, -100);
        drv_nd("R2 idle no done", 0, 0, 0, 0, 0);
        chk("R2 idle code held", int'(code_o), 4'b1001);
        chk("R2 idle fallback held", int'(fallback_o), 0);
    endtask

    task automatic t_restart;     // R10 restart mid-window
        cfg(2, 1, 100);
        drv(1, 1, 100, 0, 0);
        drv_nd("R10 restart", 0, 1, 100, 0, 0);
        drv_nd("R10 restart", 1, 1, 0, 100, -100);
        drv_nd("R10 restart", 0, 1, 0, 100, -100);
        drv_nd("R10 restart", 0, 1, 0, 100, -100);
        drv_nd("R10 restart", 0, 1, 0, 100, -100);
        expect_done("R10 restarted window", 4'b0110, 1, 0);
    endtask

    task automatic t_collide;     // R10 start on the would-be final sample
        cfg(2, 1, 100);
        drv(1, 1, 0, 100, -100);
        drv_nd("R10 collide", 0, 1, 0, 100, -100);
        drv_nd("R10 collide", 0, 1, 0, 100, -100);
        drv_nd("R10 collide", 1, 1, 0, 0, -80);
        drv_nd("R10 collide no done", 0, 1, 0, 0, -80);
        drv_nd("R10 collide no done", 0, 1, 0, 0, -80);
        drv_nd("R10 collide no done", 0, 1, 0, 0, -80);
        expect_done("R10 collided window", 4'b1100, 1, 0);
    endtask

    task automatic t_overlap;     // R11 start while the previous result latches
        cfg(2, 1, 100);
        win4(100, 0, 0);
        drv_nd("R11 overlap", 1, 1, 0, 100, -100);
        drv(0, 1, 0, 100, -100);
        chk("R11 old done", int'(done_o), 1);
        chk("R11 old code", int'(code_o), 4'b1001);
        drv_nd("R11 new window", 0, 1, 0, 100, -100);
        drv_nd("R11 new window", 0, 1, 0, 100, -100);
        expect_done("R11 new result", 4'b0110, 1, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start_i = 1'b0;
        smp_vld_i = 1'b0;
        dia_i = '0; dib_i = '0; dic_i = '0;
        cfg(2, 1, 100);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        drv(0, 1, 100, 0, 0);
        t_reset();
        t_single_a();
        t_single_c_neg();
        t_two_bc();
        t_three();
        t_unresolved();
        t_threshold();
        t_ratio();
        t_gap();
        t_idle();
        t_restart();
        t_collide();
        t_overlap();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule